// File: doc/BRIEF.md
# Fault-tolerant vector byte load sequencer

This block runs one vector load of byte elements. A start strobe hands it a base address, a signed immediate stride and a requested element count. It then issues one memory request per element in ascending index order, keeping at most one request in flight. Each good byte that comes back is zero-extended and written through a register-write port, tagged with its element index.

Only the first element is mandatory. If element 0 reports a fault, the block raises a one-cycle trap together with done, and it leaves the reported count as it was. If any later element faults, the operation stops quietly and reports how many elements were loaded before the fault. No register write happens for the faulting element. A request count of zero completes at once, with a count of zero and no memory traffic.

Address translation, caches and predication belong to the surrounding pipeline and are not part of this block.

Top module: `ffLoadSeq`

## Requirements
- R1: While reset is held and in the first cycle after it, done, trap, memReq and regWe are low and doneCount is 0.
- R2: Element i is requested at address baseAddr + signExtend(immOff) * i, modulo 2^ADDR_W. Requests go out in ascending i. A new request is issued only after the response to the previous one.
- R3: When no element faults, exactly reqCount register writes occur, with regIdx running 0, 1, ..., and done reports doneCount = reqCount with trap low.
- R4: regData of each write equals the 8-bit memRspData of that element, zero-extended to REG_W bits.
- R5: If element k > 0 faults, done reports doneCount = k with trap low. There is no write for element k and no request for any element above k.
- R6: If element 0 faults, trap is high in the single cycle that done is high, doneCount keeps its previous value, and no register write occurs.
- R7: A start with reqCount = 0 produces done with doneCount = 0 in the cycle after start is sampled, and no memory request.
- R8: Base, immediate and count are captured when start is accepted. A start pulse while an operation is running has no effect on that operation.
- R9: done is high for exactly one cycle per operation, and doneCount holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| baseAddr | input | ADDR_W | Base address |
| immOff | input | IMM_W | Signed per-element stride |
| reqCount | input | CNT_W | Requested element count |
| memReq | output | 1 | Memory read request, one cycle per element |
| memAddr | output | ADDR_W | Address of the current element |
| memRspValid | input | 1 | Response strobe for the outstanding request |
| memRspData | input | 8 | Returned byte |
| memRspFault | input | 1 | Access faulted |
| regWe | output | 1 | Register write strobe |
| regIdx | output | CNT_W | Element index being written |
| regData | output | REG_W | Zero-extended byte |
| done | output | 1 | One-cycle completion strobe |
| doneCount | output | CNT_W | Elements loaded by the last completed operation |
| trap | output | 1 | Fault on element 0, with done |

## Verification
Random operations vary the count, the sign and size of the stride, the memory latency and the faulting element. This separates full completion from truncation and from trapping. Directed cases cover a fault on the very first and the very last element, which tell the trap path apart from a truncation to zero and from an off-by-one in the count. A zero count is tried as well. A mid-operation start with a different count and changed inputs shows whether the captured operands are really held.

// File: rtl/ffLoadPkg.sv
package ffLoadPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands, index 0
    logic step;      // good element accepted, advance
    logic finEmpty;  // zero-length completion
    logic finFull;   // all elements loaded
    logic finTrunc;  // later element faulted
    logic finTrap;   // element 0 faulted
  } ctlStrobe_t;
endpackage

// File: rtl/ffLoadCtrl.sv
module ffLoadCtrl
  import ffLoadPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             memRspValid,
  input  logic             memRspFault,
  input  logic             isFirst,
  input  logic             isLast,
  output ctlStrobe_t       strb,
  output logic             memReq,
  output logic             regWe
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (reqCount == '0) begin
            strb.finEmpty = 1'b1;
          end else begin
            strb.load = 1'b1;
            nextState = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: nextState = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          if (memRspFault) begin
            if (isFirst) strb.finTrap  = 1'b1;
            else         strb.finTrunc = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strb.step = 1'b1;
            if (isLast) begin
              strb.finFull = 1'b1;
              nextState = ST_IDLE;
            end else begin
              nextState = ST_ISSUE;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign memReq = (state == ST_ISSUE);
  assign regWe  = (state == ST_WAIT) && memRspValid && !memRspFault;
endmodule

// File: rtl/ffLoadPath.sv
module ffLoadPath
  import ffLoadPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int CNT_W  = 8,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IMM_W-1:0]  immOff,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [7:0]        memRspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CNT_W-1:0]  regIdx,
  output logic [REG_W-1:0]  regData,
  output logic              isFirst,
  output logic              isLast,
  output logic              done,
  output logic [CNT_W-1:0]  doneCount,
  output logic              trap
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] addrQ;
  logic [IMM_W-1:0]  immQ;
  logic [CNT_W-1:0]  idxQ, reqQ, countQ;
  logic              doneQ, trapQ;
  logic [ADDR_W-1:0] strideExt;
  logic [CNT_W:0]    idxNext;

  assign strideExt = {{EXT_W{immQ[IMM_W-1]}}, immQ};
  assign idxNext   = {1'b0, idxQ} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      immQ   <= '0;
      idxQ   <= '0;
      reqQ   <= '0;
      countQ <= '0;
      doneQ  <= 1'b0;
      trapQ  <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ <= baseAddr;
        immQ  <= immOff;
        idxQ  <= '0;
        reqQ  <= reqCount;
      end else if (strb.step) begin
        addrQ <= addrQ + strideExt;
        idxQ  <= idxNext[CNT_W-1:0];
      end
      doneQ <= strb.finEmpty | strb.finFull | strb.finTrunc | strb.finTrap;
      trapQ <= strb.finTrap;
      if (strb.finEmpty)      countQ <= '0;
      else if (strb.finFull)  countQ <= reqQ;
      else if (strb.finTrunc) countQ <= idxQ;
    end
  end

  assign memAddr   = addrQ;
  assign regIdx    = idxQ;
  assign regData   = {{(REG_W-8){1'b0}}, memRspData};
  assign isFirst   = (idxQ == '0);
  assign isLast    = (idxNext == {1'b0, reqQ});
  assign done      = doneQ;
  assign doneCount = countQ;
  assign trap      = trapQ;
endmodule

// File: rtl/ffLoadSeq.sv
module ffLoadSeq
  import ffLoadPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int CNT_W  = 8,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [IMM_W-1:0]  immOff,
  input  logic [CNT_W-1:0]  reqCount,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic [7:0]        memRspData,
  input  logic              memRspFault,
  output logic              regWe,
  output logic [CNT_W-1:0]  regIdx,
  output logic [REG_W-1:0]  regData,
  output logic              done,
  output logic [CNT_W-1:0]  doneCount,
  output logic              trap
);
  ctlStrobe_t strb;
  logic       isFirst, isLast;

  ffLoadCtrl #(.CNT_W(CNT_W)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reqCount(reqCount),
    .memRspValid(memRspValid), .memRspFault(memRspFault),
    .isFirst(isFirst), .isLast(isLast),
    .strb(strb), .memReq(memReq), .regWe(regWe)
  );

  ffLoadPath #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .CNT_W(CNT_W), .REG_W(REG_W)) path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .baseAddr(baseAddr), .immOff(immOff), .reqCount(reqCount),
    .memRspData(memRspData),
    .memAddr(memAddr), .regIdx(regIdx), .regData(regData),
    .isFirst(isFirst), .isLast(isLast),
    .done(done), .doneCount(doneCount), .trap(trap)
  );
endmodule

// File: rtl/ffLoadChecker.sv
module ffLoadChecker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [CNT_W-1:0] reqCount,
  input logic             memReq,
  input logic             regWe,
  input logic             done,
  input logic [CNT_W-1:0] doneCount,
  input logic             trap
);
  logic             busyChk;
  logic [CNT_W-1:0] reqLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyChk  <= 1'b0;
      reqLatch <= '0;
    end else if (start && (!busyChk || done)) begin
      busyChk  <= 1'b1;
      reqLatch <= reqCount;
    end else if (done) begin
      busyChk <= 1'b0;
    end
  end

  // R2: one request in flight, the next cycle is never a request
  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R2, R7: no memory traffic outside an accepted operation
  a_r2_no_req_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busyChk |-> !memReq);

  // R6: trap only together with done
  a_r6_trap_with_done: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> done);

  // R6: count untouched on a trap
  a_r6_trap_holds_count: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> doneCount == $past(doneCount));

  // R6: no write in the completion cycle of a trap
  a_r6_no_write_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> !regWe);

  // R5: reported count never exceeds the request
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (done && !trap) |-> doneCount <= reqLatch);

  // R9: done is a single-cycle strobe
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind ffLoadSeq ffLoadChecker #(.CNT_W(CNT_W)) chk (
  .clk(clk), .rstN(rstN), .start(start), .reqCount(reqCount),
  .memReq(memReq), .regWe(regWe), .done(done),
  .doneCount(doneCount), .trap(trap)
);

// File: tb/ffLoadSeq_test.sv
module ffLoadSeq_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int IMM_W  = 16;
  localparam int CNT_W  = 8;
  localparam int REG_W  = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [IMM_W-1:0]  immOff = '0;
  logic [CNT_W-1:0]  reqCount = '0;
  logic              memReq;
  logic [ADDR_W-1:0] memAddr;
  logic              memRspValid = 1'b0;
  logic [7:0]        memRspData = '0;
  logic              memRspFault = 1'b0;
  logic              regWe;
  logic [CNT_W-1:0]  regIdx;
  logic [REG_W-1:0]  regData;
  logic              done;
  logic [CNT_W-1:0]  doneCount;
  logic              trap;

  ffLoadSeq #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .CNT_W(CNT_W), .REG_W(REG_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails = 0;

  // state of the current operation as seen by the bench
  logic [ADDR_W-1:0] curBase;
  logic [IMM_W-1:0]  curImm;
  int curN, faultAt;
  int accCount, wrCount, lat;
  bit pending, doneFlag, trapSeen, prevDone;
  logic [CNT_W-1:0] doneCntSeen;
  logic [ADDR_W-1:0] pendAddr;
  int prevCount = 0;

  function automatic logic [ADDR_W-1:0] expAddr(logic [ADDR_W-1:0] b, logic [IMM_W-1:0] im, int i);
    logic [ADDR_W-1:0] se;
    se = {{(ADDR_W-IMM_W){im[IMM_W-1]}}, im};
    return b + se * ADDR_W'(i);
  endfunction

  function automatic logic [7:0] memByte(logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA7;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model and monitor, all on the falling edge
  always @(negedge clk) begin
    memRspValid = 1'b0;
    memRspFault = 1'b0;
    if (pending) begin
      lat--;
      if (lat == 0) begin
        pending = 1'b0;
        memRspValid = 1'b1;
        memRspData = memByte(pendAddr);
        memRspFault = ((accCount - 1) == faultAt);
      end
    end
    if (rstN && memReq) begin
      check(!pending, "R2", "request while one outstanding", 1, 0);
      check(memAddr == expAddr(curBase, curImm, accCount), "R2", "element address",
            memAddr, expAddr(curBase, curImm, accCount));
      pendAddr = memAddr;
      accCount++;
      pending = 1'b1;
      lat = $urandom_range(1, 3);
    end
    #1;
    if (rstN && regWe) begin
      check(regIdx == CNT_W'(wrCount), "R3", "write index", regIdx, wrCount);
      check(regData == {{(REG_W-8){1'b0}}, memByte(expAddr(curBase, curImm, wrCount))},
            "R4", "write data", regData, memByte(expAddr(curBase, curImm, wrCount)));
      wrCount++;
    end
    if (rstN && done) begin
      check(!prevDone, "R9", "done longer than one cycle", 1, 0);
      doneFlag = 1'b1;
      doneCntSeen = doneCount;
      trapSeen = trap;
    end
    prevDone = done;
  end

  task automatic runOp(logic [ADDR_W-1:0] b, logic [IMM_W-1:0] im, int n, int f, bit poke);
    int expCnt, expAcc, expWr;
    bit expTrap;
    bit timedOut;
    logic [CNT_W-1:0] held;
    curBase = b; curImm = im; curN = n; faultAt = f;
    accCount = 0; wrCount = 0; doneFlag = 1'b0;
    @(negedge clk);
    baseAddr = b; immOff = im; reqCount = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: scramble the operand inputs once accepted
    baseAddr = ~b; immOff = ~im; reqCount = ~CNT_W'(n);
    if (poke) begin
      repeat (2) @(negedge clk);
      start = 1'b1; reqCount = 8'd3;
      @(negedge clk);
      start = 1'b0;
    end
    timedOut = 1'b1;
    for (int c = 0; c < 2000; c++) begin
      if (doneFlag) begin timedOut = 1'b0; break; end
      @(negedge clk);
    end
    if (timedOut) check(1'b0, "R9", "operation never completed", 0, 1);
    // expected result from the requirements
    if (n == 0) begin
      expCnt = 0; expTrap = 0; expAcc = 0; expWr = 0;           // R7
    end else if (f == 0) begin
      expCnt = prevCount; expTrap = 1; expAcc = 1; expWr = 0;   // R6
    end else if (f >= 0 && f < n) begin
      expCnt = f; expTrap = 0; expAcc = f + 1; expWr = f;       // R5
    end else begin
      expCnt = n; expTrap = 0; expAcc = n; expWr = n;           // R3
    end
    check(doneCntSeen == CNT_W'(expCnt), (f == 0) ? "R6" : (n == 0) ? "R7" : (f > 0 && f < n) ? "R5" : "R3",
          "doneCount", doneCntSeen, expCnt);
    check(trapSeen == expTrap, (f == 0 && n > 0) ? "R6" : "R5", "trap", trapSeen, expTrap);
    check(accCount == expAcc, (poke) ? "R8" : (n == 0) ? "R7" : "R5", "memory requests", accCount, expAcc);
    check(wrCount == expWr, (poke) ? "R8" : "R3", "register writes", wrCount, expWr);
    if (!expTrap) prevCount = expCnt;
    held = doneCount;
    repeat (2) @(negedge clk);
    check(!done, "R9", "done after completion", done, 0);
    check(doneCount == held, "R9", "doneCount held", doneCount, held);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !trap, "R1", "done/trap in reset", {done, trap}, 0);
    check(!memReq && !regWe, "R1", "memReq/regWe in reset", {memReq, regWe}, 0);
    check(doneCount == 0, "R1", "doneCount in reset", doneCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !memReq && !regWe && doneCount == 0, "R1", "after reset", done, 0);

    runOp(32'h0000_1007, 16'd1, 0, -1, 0);          // R7 zero count
    runOp(32'h0000_1007, 16'd1, 1, -1, 0);          // R3 single
    runOp(32'h0001_0000, 16'd8, 5, -1, 0);          // R2 R3 R4 positive stride
    runOp(32'h0000_0010, 16'hFFFC, 6, -1, 0);       // R2 negative stride, wrap
    runOp(32'h0000_2000, 16'd4, 7, 0, 0);           // R6 first element faults
    runOp(32'h0000_3000, 16'd2, 6, 3, 0);           // R5 truncate mid
    runOp(32'h0000_4000, 16'd1, 5, 4, 0);           // R5 fault on last element
    runOp(32'h0000_5000, 16'd3, 1, 0, 0);           // R6 single element trap
    runOp(32'h0000_6000, 16'd16, 6, -1, 1);         // R8 start while busy
    runOp(32'h0000_7000, 16'd1, 4, 1, 0);           // R5 truncate to one
    for (int k = 0; k < 60; k++) begin
      int n, f;
      n = $urandom_range(0, 12);
      f = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, 13));
      runOp($urandom, 16'($urandom), n, f, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule